// File: doc/BRIEF.md
# Programmable Video Clock Divider

This block takes a single fast dot clock and derives three slower signals from it: a video clock, a shift clock and a load strobe. The shift clock paces the external video memory. The load strobe runs at the same rate and marks when pixel data is captured. A 6-bit selection, written through a one-cycle register-write port, sets the divide ratio of the video clock and of the shift clock independently. Each ratio is a power of two from 1 to 32. Two further codes per field park the output at a fixed level instead of dividing.

All divided outputs are registered taps of one shared free-running counter, so every ratio has a 50% duty cycle and no glitches. Ratio 1 is the exception: the dot clock itself is passed through an AND gate whose enable is updated on the falling edge. A blanking input stops the shift clock synchronously, while the load strobe keeps running. When blanking ends, the shift clock restarts only at the start of a full divided period. A write that changes either ratio drops a stability flag for a parameterized number of dot-clock cycles, which covers the settling time.

Top module: `pcd_top`

## Requirements
- R1: The video-clock code is `wr_data_i[5:3]`. Code k in 1..5 makes `vclk_o` a square wave of period 2^k dot cycles. Its level after the n-th rising edge since reset is bit k-1 of n.
- R2: The shift-clock code is `wr_data_i[2:0]`. It uses the same mapping as R1 for `sclk_o`, taken from the same edge count n.
- R3: A video-clock code of 110 or 111 holds `vclk_o` high. Reset loads 111.
- R4: A shift-clock code of 110 or 111 holds both `sclk_o` and `load_o` low. Reset loads 111.
- R5: Bits 7:6 of a write are ignored. A write that differs from the stored selection only in those bits changes no output and leaves `clocks_stable_o` high.
- R6: `blank_i` high at a rising edge forces `sclk_o` low for the following cycle. In ratio-1 mode, `blank_i` high at a falling edge keeps `sclk_o` low until the next falling edge.
- R7: `load_o` follows the shift-clock code exactly as `sclk_o` would without blanking. `blank_i` has no effect on it.
- R8: After blanking ends, after a reset, or after a change out of hold or ratio-1 mode, a divided `sclk_o` restarts only at an edge where n mod 2^k = 0. Its first period is therefore complete.
- R9: A write whose bits 5:0 differ from the stored selection holds `clocks_stable_o` low for exactly SETTLE_CYCLES cycles after the write edge. Another changing write inside that window restarts the window.
- R10: Code 000 passes the dot clock through, gated by an enable that is updated on the falling edge. In ratio-1 mode, the output is high while the clock is high and is low in the low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Selection write strobe |
| wr_data_i | input | 8 | Selection write data |
| blank_i | input | 1 | Blanking active, high |
| vclk_o | output | 1 | Divided video clock |
| sclk_o | output | 1 | Divided shift clock, gated by blanking |
| load_o | output | 1 | Pixel load strobe, never gated |
| clocks_stable_o | output | 1 | Low while a new ratio is settling |

## Verification
The bench keeps the counter width at its default of 5 bits, so every ratio from 1 to 32 is reachable, including the full 32-cycle wrap of the shared counter. It sets SETTLE_CYCLES to 4 so that a second changing write can land inside an open settling window, and the test can check that the window restarts. Blanking is raised and released at odd phases of slow ratios, which exercises the wait for a full period before the shift clock restarts. A ratio-1 phase is checked in both halves of the clock period.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int unsigned CODE_W = 3;

  typedef logic [CODE_W-1:0] ratio_code_t;

  typedef struct packed {
    ratio_code_t vclk;
    ratio_code_t sclk;
  } clk_sel_t;

  localparam ratio_code_t CODE_HOLD = 3'b111;
  localparam clk_sel_t SEL_RESET = '{vclk: CODE_HOLD, sclk: CODE_HOLD};

  function automatic logic is_hold(ratio_code_t c);
    return c[2:1] == 2'b11;
  endfunction
endpackage

// File: rtl/pcd_ctrl_reg.sv
module pcd_ctrl_reg
  import pcd_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output clk_sel_t   sel_o,
  output logic       stable_o
);
  localparam int unsigned SW = $clog2(SETTLE_CYCLES + 1);

  clk_sel_t        sel_q;
  clk_sel_t        sel_new;
  logic [SW-1:0]   settle_q;
  logic            change;

  assign sel_new = clk_sel_t'(wr_data_i[5:0]);
  assign change  = wr_en_i && (sel_new != sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= SEL_RESET;
      settle_q <= '0;
    end else begin
      if (wr_en_i) sel_q <= sel_new;
      if (change) settle_q <= SW'(SETTLE_CYCLES);
      else if (settle_q != '0) settle_q <= settle_q - 1'b1;
    end
  end

  assign sel_o    = sel_q;
  assign stable_o = (settle_q == '0);
endmodule

// File: rtl/pcd_div_counter.sv
module pcd_div_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_next_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_next_o = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_next_o;
  end
endmodule

// File: rtl/pcd_clk_out.sv
module pcd_clk_out
  import pcd_pkg::*;
#(
  parameter int unsigned CNT_W    = 5,
  parameter bit          HOLD_VAL = 1'b0,
  parameter bit          GATED    = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ratio_code_t      code_i,
  input  logic [CNT_W-1:0] cnt_next_i,
  input  logic             blank_i,
  output logic             clk_o
);
  logic             hold, bypass, blanked;
  logic [CNT_W-1:0] mask, tap_sel;
  logic             tap, period_start, run_next;
  logic             run_q, q, pass_en_q;

  assign hold    = is_hold(code_i) || (int'(code_i) > int'(CNT_W));
  assign bypass  = (code_i == '0);
  assign blanked = GATED && blank_i;

  // low code bits of the counter select the tap and the period boundary
  assign mask         = CNT_W'((1 << code_i) - 1);
  assign tap_sel      = CNT_W'(1) << (code_i - 3'd1);
  assign tap          = |(cnt_next_i & tap_sel);
  assign period_start = ((cnt_next_i & mask) == '0);

  // run restarts only at a period boundary, so no runt pulse
  assign run_next = (hold || bypass || blanked) ? 1'b0 :
                    (period_start ? 1'b1 : run_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      q     <= HOLD_VAL;
    end else begin
      run_q <= run_next;
      if (hold)        q <= HOLD_VAL;
      else if (bypass) q <= 1'b0;
      else             q <= tap & (GATED ? run_next : 1'b1);
    end
  end

  // enable for the pass-through path changes while the clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pass_en_q <= 1'b0;
    else         pass_en_q <= bypass && !blanked;
  end

  assign clk_o = bypass ? (clk_i & pass_en_q) : q;
endmodule

// File: rtl/pcd_top.sv
module pcd_top
  import pcd_pkg::*;
#(
  parameter int unsigned CNT_W         = 5,
  parameter int unsigned SETTLE_CYCLES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       blank_i,
  output logic       vclk_o,
  output logic       sclk_o,
  output logic       load_o,
  output logic       clocks_stable_o
);
  localparam int unsigned NUM_OUT = 3;
  // output 0: video clock, 1: shift clock, 2: load strobe
  localparam logic [NUM_OUT-1:0] HOLD_VALS  = 3'b001;
  localparam logic [NUM_OUT-1:0] GATED_MASK = 3'b010;

  clk_sel_t          sel;
  logic [CNT_W-1:0]  cnt_next;
  ratio_code_t       codes [NUM_OUT];
  logic [NUM_OUT-1:0] outs;

  pcd_ctrl_reg #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .sel_o    (sel),
    .stable_o (clocks_stable_o)
  );

  pcd_div_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_next_o(cnt_next)
  );

  assign codes[0] = sel.vclk;
  assign codes[1] = sel.sclk;
  assign codes[2] = sel.sclk;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    pcd_clk_out #(
      .CNT_W   (CNT_W),
      .HOLD_VAL(HOLD_VALS[g]),
      .GATED   (GATED_MASK[g])
    ) u_out (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .code_i    (codes[g]),
      .cnt_next_i(cnt_next),
      .blank_i   (blank_i),
      .clk_o     (outs[g])
    );
  end

  assign vclk_o = outs[0];
  assign sclk_o = outs[1];
  assign load_o = outs[2];
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker
  import pcd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       blank_i,
  input logic       vclk_o,
  input logic       sclk_o,
  input logic       load_o,
  input logic       clocks_stable_o,
  input clk_sel_t   sel_i
);
  a_r3_vclk_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_hold($past(sel_i.vclk)) && is_hold(sel_i.vclk)) |-> vclk_o);

  a_r4_sclk_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_hold($past(sel_i.sclk)) && is_hold(sel_i.sclk)) |-> (!sclk_o && !load_o));

  a_r6_blank_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(blank_i) && $past(sel_i.sclk) != '0 && sel_i.sclk != '0) |-> !sclk_o);

  a_r9_settle_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && clk_sel_t'(wr_data_i[5:0]) != sel_i) |=> !clocks_stable_o);

  a_r5_upper_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && clk_sel_t'(wr_data_i[5:0]) == sel_i && clocks_stable_o) |=> clocks_stable_o);
endmodule

bind pcd_top pcd_checker i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .wr_data_i      (wr_data_i),
  .blank_i        (blank_i),
  .vclk_o         (vclk_o),
  .sclk_o         (sclk_o),
  .load_o         (load_o),
  .clocks_stable_o(clocks_stable_o),
  .sel_i          (sel)
);

// File: tb/test_pcd_top.sv
`timescale 1ns/1ps
module test_pcd_top;
  localparam int SETTLE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       blank = 1'b0;
  logic       vclk, sclk, load, stable;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcd_top #(.CNT_W(5), .SETTLE_CYCLES(SETTLE)) i_pcd_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .blank_i(blank), .vclk_o(vclk), .sclk_o(sclk), .load_o(load),
    .clocks_stable_o(stable)
  );

  // reference model state
  int n = 0;
  int vc = 7, sc = 7;
  int settle = 0;
  bit run = 0, vq = 1, sq = 0, lq = 0;
  bit en_v = 0, en_s = 0, en_l = 0;

  function automatic bit bitk(int cnt, int k);
    return bit'((cnt >> (k - 1)) & 1);
  endfunction

  function automatic bit startk(int cnt, int k);
    return (cnt % (1 << k)) == 0;
  endfunction

  task automatic chk(string tag, string nm, logic a, logic e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, a, e, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      bit vh, sh;
      int nc_v, nc_s;
      vh = vc >= 6;
      sh = sc >= 6;
      n++;
      vq = vh ? 1'b1 : (vc == 0 ? 1'b0 : bitk(n, vc));
      if (sh || sc == 0 || blank) run = 0;
      else if (startk(n, sc)) run = 1;
      sq = sh ? 1'b0 : (sc == 0 ? 1'b0 : (run & bitk(n, sc)));
      lq = sh ? 1'b0 : (sc == 0 ? 1'b0 : bitk(n, sc));
      nc_v = int'(wr_data[5:3]);
      nc_s = int'(wr_data[2:0]);
      if (wr_en && (nc_v != vc || nc_s != sc)) settle = SETTLE;
      else if (settle > 0) settle--;
      if (wr_en) begin
        vc = nc_v;
        sc = nc_s;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      en_v = (vc == 0);
      en_s = (sc == 0) && !blank;
      en_l = (sc == 0);
    end
  end

  // high-phase sample
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(vc >= 6 ? "R3" : (vc == 0 ? "R10" : "R1"), "vclk_hi", vclk, vc == 0 ? en_v : vq);
      chk(sc >= 6 ? "R4" : (sc == 0 ? "R10 R6" : "R2 R6 R8"), "sclk_hi", sclk, sc == 0 ? en_s : sq);
      chk("R7", "load_hi", load, sc == 0 ? en_l : lq);
      chk("R9 R5", "stable", stable, settle == 0);
    end
  end

  // low-phase sample
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(vc >= 6 ? "R3" : (vc == 0 ? "R10" : "R1"), "vclk_lo", vclk, vc == 0 ? 1'b0 : vq);
      chk(sc >= 6 ? "R4" : (sc == 0 ? "R10 R6" : "R2 R6 R8"), "sclk_lo", sclk, sc == 0 ? 1'b0 : sq);
      chk("R7", "load_lo", load, sc == 0 ? 1'b0 : lq);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int cyc);
    repeat (cyc) @(posedge clk);
  endtask

  task automatic set_blank(input logic v);
    @(posedge clk); #1;
    blank = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // reset state: R3 R4, stable high
    chk("R3", "reset_vclk", vclk, 1'b1);
    chk("R4", "reset_sclk", sclk, 1'b0);
    chk("R4", "reset_load", load, 1'b0);
    chk("R9", "reset_stable", stable, 1'b1);
    rst_n = 1'b1;
    idle(20);
    wr(8'h0A);           // vclk /2, sclk /4
    idle(60);
    wr(8'hCA);           // R5: only bits 7:6 differ
    idle(20);
    wr(8'h2B);           // vclk /32, sclk /8
    idle(13);
    set_blank(1'b1);     // R6 at odd phase
    idle(17);
    set_blank(1'b0);     // R8 restart on full period
    idle(70);
    wr(8'h00);           // R10 ratio 1 on both
    idle(10);
    set_blank(1'b1);
    idle(5);
    set_blank(1'b0);
    idle(15);
    wr(8'h25);           // vclk /16, sclk /32
    idle(21);
    set_blank(1'b1);
    idle(9);
    set_blank(1'b0);
    idle(80);
    wr(8'h11);           // R9 restart window
    idle(1);
    wr(8'h1C);
    idle(40);
    wr(8'h3F);           // back to hold
    idle(20);
    finish_run();
  end
endmodule